// File: doc/BRIEF.md
# DRAM Refresh Request Generator

This block sets the pace of refresh for external DRAM that uses CAS-before-RAS refresh. Software writes a configuration word that holds an 11-bit reload count, a unit enable and one enable bit for each of two DRAM banks. While the unit is active, a down-counter runs from the reload value. Each time the count period ends, the block raises a refresh request to the bus sequencer, and the sequencer performs the actual strobing.

The request stays high until the sequencer acknowledges it. While the request is high, the block drives a constant all-ones refresh address. CAS-before-RAS refresh takes its row from inside the DRAM, so no row counter is kept. If a second period ends while a request is still waiting, the block keeps only one request and records the miss in a sticky overrun flag. Any configuration write restarts the countdown, withdraws an unacknowledged request and clears the overrun flag.

Top module: `dram_refresh_gen`

## Requirements
- R1: After reset, `ref_req_o` is 0, `overrun_o` is 0, `ref_addr_o` is 0, and the unit is inactive (reload 0, enable 0, banks 0).
- R2: The unit is active when the enable bit is 1, at least one bank bit is 1 and the reload value N is nonzero (1 to 2047). While it is active, the request rises on the Nth rising clock edge after the write edge, and then on every Nth edge after that.
- R3: If the enable bit is 0, or both bank-enable bits (`cfg_bank_en_i[0]` for bank 0, `cfg_bank_en_i[1]` for bank 1) are 0, no request is ever raised. Either bank bit alone is enough to allow requests.
- R4: A reload value of 0 disables the unit, and no request is raised.
- R5: The request stays high until `ref_ack_i` is sampled high with it, and then falls on that edge. If a period ends on the same edge as the acknowledge, the request stays high as a new request and no overrun is recorded.
- R6: A period that ends while a request is high and not being acknowledged leaves one request pending and sets `overrun_o`. The flag stays set until the next configuration write or reset.
- R7: A configuration write (`cfg_we_i` high at an edge) loads the new values, restarts the countdown from the new reload value, drops `ref_req_o` and clears `overrun_o` on that edge.
- R8: `ref_addr_o` is 20'hFFFFF in every cycle where `ref_req_o` is high, and 0 otherwise.
- R9: The counter is 11 bits wide, so a reload of 2047 gives a 2047-cycle request period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_reload_i | input | 11 | Reload count written on strobe |
| cfg_en_i | input | 1 | Unit enable written on strobe |
| cfg_bank_en_i | input | 2 | Per-bank DRAM enables written on strobe |
| ref_ack_i | input | 1 | Sequencer acknowledge of the pending refresh |
| ref_req_o | output | 1 | Refresh request to the sequencer |
| ref_addr_o | output | 20 | Refresh address, all ones while requesting |
| overrun_o | output | 1 | Sticky flag for a missed refresh period |

## Verification
The assertions assume that the sequencer raises `ref_ack_i` only while `ref_req_o` is high, and that any acknowledge is for the request that is currently pending. The bench meets this by deriving its acknowledge from the request it samples, optionally after a programmable delay. It drops the acknowledge in the phases that provoke overruns. Configuration writes are one-cycle strobes, placed both while a request is waiting and while the countdown is running, so that the withdraw and restart paths are exercised.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  parameter int CNT_W  = 11;
  parameter int ADDR_W = 20;
  parameter int BANKS  = 2;

  typedef struct packed {
    logic [CNT_W-1:0] reload;
    logic             en;
    logic [BANKS-1:0] bank_en;
  } ref_cfg_t;
endpackage

// File: rtl/dram_ref_cfg.sv
module dram_ref_cfg
  import dram_ref_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  ref_cfg_t         wdata_i,
  output ref_cfg_t         cfg_o,
  output logic             active_o
);
  logic [BANKS-1:0] bank_q;
  logic [CNT_W-1:0] reload_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      en_q     <= 1'b0;
    end else if (we_i) begin
      reload_q <= wdata_i.reload;
      en_q     <= wdata_i.en;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   bank_q[b] <= 1'b0;
      else if (we_i) bank_q[b] <= wdata_i.bank_en[b];
    end
  end

  assign cfg_o    = '{reload: reload_q, en: en_q, bank_en: bank_q};
  // zero reload counts as disabled
  assign active_o = en_q && (|bank_q) && (reload_q != '0);
endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer
  import dram_ref_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] restart_val_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = active_i && !restart_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= restart_val_i;
    else if (!active_i) cnt_q <= reload_i;
    else if (expire_o)  cnt_q <= reload_i;
    else                cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/dram_ref_req.sv
module dram_ref_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic active_i,
  input  logic expire_i,
  input  logic ack_i,
  output logic req_o,
  output logic overrun_o
);
  logic req_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (flush_i) begin
      req_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (!active_i) begin
      req_q <= 1'b0;
    end else if (expire_i) begin
      req_q <= 1'b1;
      // a still-unserved request merges with the new one
      if (req_q && !ack_i) ovr_q <= 1'b1;
    end else if (ack_i) begin
      req_q <= 1'b0;
    end
  end

  assign req_o     = req_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/dram_refresh_gen.sv
module dram_refresh_gen
  import dram_ref_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CNT_W-1:0]  cfg_reload_i,
  input  logic              cfg_en_i,
  input  logic [BANKS-1:0]  cfg_bank_en_i,
  input  logic              ref_ack_i,
  output logic              ref_req_o,
  output logic [ADDR_W-1:0] ref_addr_o,
  output logic              overrun_o
);
  localparam logic [ADDR_W-1:0] REF_ADDR = '1;

  ref_cfg_t wdata, cfg;
  logic     active, expire;

  assign wdata = '{reload: cfg_reload_i, en: cfg_en_i, bank_en: cfg_bank_en_i};

  dram_ref_cfg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (wdata),
    .cfg_o    (cfg),
    .active_o (active)
  );

  dram_ref_timer u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .restart_i     (cfg_we_i),
    .restart_val_i (cfg_reload_i),
    .active_i      (active),
    .reload_i      (cfg.reload),
    .expire_o      (expire)
  );

  dram_ref_req u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (cfg_we_i),
    .active_i  (active),
    .expire_i  (expire),
    .ack_i     (ref_ack_i),
    .req_o     (ref_req_o),
    .overrun_o (overrun_o)
  );

  assign ref_addr_o = ref_req_o ? REF_ADDR : '0;
endmodule

// File: rtl/dram_refresh_gen_chk.sv
module dram_refresh_gen_chk
  import dram_ref_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              ref_ack_i,
  input logic              ref_req_o,
  input logic [ADDR_W-1:0] ref_addr_o,
  input logic              overrun_o,
  input ref_cfg_t          cfg
);
  p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg.en || cfg.bank_en == '0) |-> !ref_req_o);
  p_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.reload == '0) |-> !ref_req_o);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_ack_i && !cfg_we_i) |=> ref_req_o);
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !cfg_we_i) |=> overrun_o);
  p_wr_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (!ref_req_o && !overrun_o));
  p_addr_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> (&ref_addr_o));
  p_addr_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_req_o |-> (ref_addr_o == '0));
endmodule

bind dram_refresh_gen dram_refresh_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .ref_ack_i  (ref_ack_i),
  .ref_req_o  (ref_req_o),
  .ref_addr_o (ref_addr_o),
  .overrun_o  (overrun_o),
  .cfg        (cfg)
);

// File: tb/dram_refresh_gen_bench.sv
module dram_refresh_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [10:0] cfg_reload = '0;
  logic        cfg_en = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic        ack = 1'b0;
  logic        req, ovr;
  logic [19:0] addr;

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  int    ack_mode = 0;   // 0 none, 1 ack after ack_dly cycles of request
  int    ack_dly = 0;
  int    req_age = 0;
  int    rise_cnt = 0;

  // reference model state
  int m_reload = 0, m_ph = 0;
  bit m_en = 0, m_req = 0, m_ovr = 0;
  bit [1:0] m_bank = 0;

  always #5 clk = ~clk;

  dram_refresh_gen u_dram_refresh_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_reload_i(cfg_reload),
    .cfg_en_i(cfg_en), .cfg_bank_en_i(cfg_bank), .ref_ack_i(ack),
    .ref_req_o(req), .ref_addr_o(addr), .overrun_o(ovr)
  );

  always @(posedge clk or negedge rst_n) begin
    bit act, ex, had;
    if (!rst_n) begin
      m_reload = 0; m_en = 0; m_bank = 0; m_ph = 0; m_req = 0; m_ovr = 0;
    end else if (cfg_we) begin
      m_reload = cfg_reload; m_en = cfg_en; m_bank = cfg_bank;
      m_ph = 0; m_req = 0; m_ovr = 0;
    end else begin
      act = m_en && (m_bank != 0) && (m_reload != 0);
      if (!act) begin
        m_ph = 0; m_req = 0;
      end else begin
        m_ph++;
        ex  = (m_ph % m_reload) == 0;
        had = m_req && !ack;
        if (ex) begin
          if (had) m_ovr = 1;
          if (!m_req || !had) rise_cnt++;
          m_req = 1;
        end else m_req = had;
      end
    end
  end

  task automatic check(string what, logic [31:0] act_v, logic [31:0] exp_v);
    n_tests++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act_v, exp_v);
    end
  endtask

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check("req", 32'(req), 32'(m_req));
      check("overrun", 32'(ovr), 32'(m_ovr));
      check("addr", 32'(addr), m_req ? 32'hFFFFF : 32'h0);
    end
  end

  // acknowledge driver: only while a request is seen
  always @(negedge clk) begin
    if (req) req_age++; else req_age = 0;
    ack <= (ack_mode == 1) && req && (req_age > ack_dly);
  end

  task automatic wr(int rl, bit en, bit [1:0] bk);
    @(negedge clk);
    cfg_we <= 1'b1; cfg_reload <= 11'(rl); cfg_en <= en; cfg_bank <= bk;
    @(negedge clk);
    cfg_we <= 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int rc0;
    #23;
    cur_req = "R1";
    check("reset req", 32'(req), 0);
    check("reset overrun", 32'(ovr), 0);
    check("reset addr", 32'(addr), 0);
    rst_n = 1'b1;
    run(10);
    check("idle req R1", 32'(req), 0);

    cur_req = "R2"; ack_mode = 1; ack_dly = 1;
    rc0 = rise_cnt;
    wr(5, 1, 2'b01);
    run(60);
    check("R2 rises in 60 cycles at N=5", 32'(rise_cnt - rc0), 12);
    wr(13, 1, 2'b10);
    run(80);

    cur_req = "R3";
    wr(4, 1, 2'b00); run(30); check("R3 no bank", 32'(req), 0);
    wr(4, 0, 2'b11); run(30); check("R3 unit off", 32'(req), 0);
    wr(4, 1, 2'b10); run(30);

    cur_req = "R4";
    wr(0, 1, 2'b11); run(40); check("R4 zero reload", 32'(req), 0);

    cur_req = "R5"; ack_dly = 3;
    wr(6, 1, 2'b11); run(60);
    ack_dly = 0;
    wr(1, 1, 2'b01); run(20);     // ack coincides with every expiry

    cur_req = "R6"; ack_mode = 0;
    wr(3, 1, 2'b01); run(20);
    check("R6 overrun set", 32'(ovr), 1);
    check("R6 single req", 32'(req), 1);
    ack_mode = 1; ack_dly = 0; run(20);
    check("R6 overrun sticky", 32'(ovr), 1);

    cur_req = "R7"; ack_mode = 0;
    wr(4, 1, 2'b01); run(6);
    wr(9, 1, 2'b01);              // withdraws pending request
    check("R7 withdrawn", 32'(req), 0);
    run(5); wr(9, 1, 2'b01); run(20);

    cur_req = "R8"; ack_mode = 1; ack_dly = 2;
    wr(7, 1, 2'b11); run(40);

    cur_req = "R9"; ack_dly = 5;
    rc0 = rise_cnt;
    wr(2047, 1, 2'b01); run(2047 * 3 + 4);
    check("R9 rises at N=2047", 32'(rise_cnt - rc0), 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule